// File: doc/BRIEF.md
# Base/Mask Stream Register Snoop Filter

This block sits beside a set-associative cache and answers snoop queries with either "may be present" or "definitely absent". It never sees the cache contents. It keeps a few stream registers, each a base address plus a mask. A mask bit of 1 means every covered address agrees with the base at that bit, and a mask bit of 0 means that bit may take any value. Each cache fill is folded into one register, and that register's coverage widens only as much as the fill needs.

Coverage only grows, so over time the registers would cover nearly everything. To prevent this, the block watches cache replacements, which are round-robin within each set. When every set has had as many replacements as it has ways, every line now in the cache must have arrived since the last such point. At that moment the live bank is moved into a shadow bank and the live bank starts empty. Queries look at both banks. The contents displaced from the shadow bank are dropped.

Top module: `stream_filter`

## Requirements
- R1: After reset, no register is valid and every query address returns absent (`qry_maybe` = 0).
- R2: `qry_maybe` is 1 exactly when some valid register in either bank has `((qry_addr ^ base) & mask) == 0`.
- R3: A fill that no valid live register already covers, arriving while a live register is empty, goes into the lowest-numbered empty register with base = fill address and an all-ones mask.
- R4: A fill whose address some valid live register already covers changes no register's coverage.
- R5: When every live register is valid and none covers the fill, the fill merges into the register whose mask would lose the fewest bits, the lowest index winning ties. That register clears its mask bits wherever the fill address differs from its base.
- R6: Each set keeps a replacement count that rises by one per fill to that set and saturates at WAYS. The cache wraps on the fill that leaves every set's count at WAYS. `fill_way` must equal the set's round-robin position, which starts at way 0 after reset.
- R7: On a wrap, the live bank, including the wrapping fill, becomes the shadow bank; the live bank is then emptied and all counts return to 0.
- R8: Apart from a wrap, the shadow bank never changes. At each wrap its previous contents are discarded.
- R9: Addresses recorded before the most recent wrap still return "may be present" through the shadow bank, while fills after it land in the live bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A line is being filled into the cache this cycle |
| fill_addr | input | ADDR_W | Line address of the fill |
| fill_set | input | $clog2(SETS) | Cache set receiving the fill |
| fill_way | input | $clog2(WAYS) | Way being replaced (round-robin position) |
| qry_addr | input | ADDR_W | Snoop query line address |
| qry_maybe | output | 1 | 1 = may be present, 0 = definitely absent |

## Verification
The hardest behaviour to reach is the discard of old shadow contents at a second wrap. It needs two complete round-robin passes over every set, and the earlier epoch's addresses must differ from the later epoch's coverage at some bit. The stimulus sends a directed first epoch that saturates one set early without wrapping. It then sends a second epoch of addresses chosen so that the old address is clearly outside the new coverage. After that a pseudo-random fill stream runs through further wraps. Every one of the 4096 query addresses is compared against an arithmetic model at each stage.

// File: rtl/sfilt_pkg.sv
package sfilt_pkg;
    typedef enum logic [1:0] {
        PICK_HOLD  = 2'd0,
        PICK_EMPTY = 2'd1,
        PICK_MERGE = 2'd2
    } pick_kind_e;
endpackage

// File: rtl/sfilt_match.sv
module sfilt_match #(
    parameter int AW = 12
) (
    input  logic          valid,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    assign hit = valid && (((addr ^ base) & mask) == '0);
endmodule

// File: rtl/sfilt_pick.sv
module sfilt_pick
    import sfilt_pkg::*;
#(
    parameter int AW   = 12,
    parameter int NREG = 4,
    parameter int IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [NREG-1:0]         valid,
    input  logic [NREG-1:0][AW-1:0] base,
    input  logic [NREG-1:0][AW-1:0] mask,
    input  logic [AW-1:0]           addr,
    output logic [IW-1:0]           sel,
    output pick_kind_e              kind,
    output logic [AW-1:0]           new_base,
    output logic [AW-1:0]           new_mask
);
    localparam int CW = $clog2(2 * AW + 3);

    logic [CW-1:0] cost [NREG];
    logic [CW-1:0] best_c;

    // Cost: covered = 0, empty = 1, widening = 2 * bits lost.
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            cost[i] = CW'(1);
            if (valid[i]) begin
                cost[i] = '0;
                for (int b = 0; b < AW; b++) begin
                    cost[i] = cost[i] + CW'(2 * int'(mask[i][b] & (base[i][b] ^ addr[b])));
                end
            end
        end
    end

    always_comb begin
        best_c = '1;
        sel    = '0;
        for (int i = 0; i < NREG; i++) begin
            if (cost[i] < best_c) begin
                best_c = cost[i];
                sel    = IW'(i);
            end
        end
        if (best_c == '0)            kind = PICK_HOLD;
        else if (best_c == CW'(1))   kind = PICK_EMPTY;
        else                         kind = PICK_MERGE;
        case (kind)
            PICK_EMPTY: begin
                new_base = addr;
                new_mask = '1;
            end
            PICK_MERGE: begin
                new_base = base[sel];
                new_mask = mask[sel] & ~(base[sel] ^ addr);
            end
            default: begin
                new_base = base[sel];
                new_mask = mask[sel];
            end
        endcase
    end
endmodule

// File: rtl/sfilt_wrap.sv
module sfilt_wrap #(
    parameter int SETS = 4,
    parameter int WAYS = 2,
    parameter int SW   = (SETS > 1) ? $clog2(SETS) : 1,
    parameter int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_valid,
    input  logic [SW-1:0] fill_set,
    input  logic [WW-1:0] fill_way,
    output logic          wrap
);
    localparam int CW = $clog2(WAYS + 1);

    typedef struct packed {
        logic [SETS-1:0][CW-1:0] cnt;
        logic [SETS-1:0][WW-1:0] ptr;
    } wst_t;

    wst_t w_d, w_q;
    logic all_full;

    always_comb begin
        w_d  = w_q;
        wrap = 1'b0;
        if (fill_valid) begin
            if (w_q.cnt[fill_set] < CW'(WAYS)) begin
                w_d.cnt[fill_set] = w_q.cnt[fill_set] + 1'b1;
            end
            w_d.ptr[fill_set] = (w_q.ptr[fill_set] == WW'(WAYS - 1)) ? '0
                                                                      : w_q.ptr[fill_set] + 1'b1;
        end
        all_full = 1'b1;
        for (int s = 0; s < SETS; s++) begin
            all_full = all_full & (w_d.cnt[s] == CW'(WAYS));
        end
        if (fill_valid && all_full) begin
            wrap  = 1'b1;
            w_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    AST_RR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (fill_way == w_q.ptr[fill_set])); // R6
endmodule

// File: rtl/stream_filter.sv
module stream_filter
    import sfilt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int NREG   = 4,
    parameter int SETW   = (SETS > 1) ? $clog2(SETS) : 1,
    parameter int WAYW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [SETW-1:0]   fill_set,
    input  logic [WAYW-1:0]   fill_way,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              qry_maybe
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    typedef struct packed {
        logic [NREG-1:0]             act_v;
        logic [NREG-1:0][ADDR_W-1:0] act_b;
        logic [NREG-1:0][ADDR_W-1:0] act_m;
        logic [NREG-1:0]             shd_v;
        logic [NREG-1:0][ADDR_W-1:0] shd_b;
        logic [NREG-1:0][ADDR_W-1:0] shd_m;
    } bank_t;

    bank_t st_d, st_q;

    logic [IW-1:0]     pick_sel;
    pick_kind_e        pick_kind;
    logic [ADDR_W-1:0] pick_base, pick_mask;
    logic              wrap;
    logic [NREG-1:0]   hit_act, hit_shd;

    sfilt_pick #(.AW(ADDR_W), .NREG(NREG), .IW(IW)) u_pick (
        .valid   (st_q.act_v),
        .base    (st_q.act_b),
        .mask    (st_q.act_m),
        .addr    (fill_addr),
        .sel     (pick_sel),
        .kind    (pick_kind),
        .new_base(pick_base),
        .new_mask(pick_mask)
    );

    sfilt_wrap #(.SETS(SETS), .WAYS(WAYS), .SW(SETW), .WW(WAYW)) u_wrap (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_valid(fill_valid),
        .fill_set  (fill_set),
        .fill_way  (fill_way),
        .wrap      (wrap)
    );

    always_comb begin
        st_d = st_q;
        if (fill_valid) begin
            st_d.act_v[pick_sel] = 1'b1;
            st_d.act_b[pick_sel] = pick_base;
            st_d.act_m[pick_sel] = pick_mask;
        end
        if (wrap) begin
            st_d.shd_v = st_d.act_v;
            st_d.shd_b = st_d.act_b;
            st_d.shd_m = st_d.act_m;
            st_d.act_v = '0;
            st_d.act_b = '0;
            st_d.act_m = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_lookup
        sfilt_match #(.AW(ADDR_W)) u_act (
            .valid(st_q.act_v[g]), .base(st_q.act_b[g]), .mask(st_q.act_m[g]),
            .addr (qry_addr), .hit(hit_act[g])
        );
        sfilt_match #(.AW(ADDR_W)) u_shd (
            .valid(st_q.shd_v[g]), .base(st_q.shd_b[g]), .mask(st_q.shd_m[g]),
            .addr (qry_addr), .hit(hit_shd[g])
        );

        AST_MASK_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(st_q.act_v[g]) && st_q.act_v[g])
                |-> ((st_q.act_m[g] & ~$past(st_q.act_m[g])) == '0)); // R5
    end

    assign qry_maybe = (|hit_act) | (|hit_shd);

    AST_WRAP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (st_q.act_v == '0)); // R7

    AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(st_q.shd_v) && $stable(st_q.shd_b) && $stable(st_q.shd_m))); // R8

    AST_COVERED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !wrap && pick_kind == PICK_HOLD) |=> ($stable(st_q.act_v) && $stable(st_q.act_m))); // R4

    AST_EMPTY_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act_v == '0 && st_q.shd_v == '0) |-> !qry_maybe); // R2
endmodule

// File: tb/stream_filter_test.sv
module stream_filter_test;
    localparam int AW = 12;
    localparam int SETS = 4;
    localparam int WAYS = 2;
    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [1:0]    fill_set = '0;
    logic [0:0]    fill_way = '0;
    logic [AW-1:0] qry_addr = '0;
    logic          qry_maybe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [AW-1:0] ab [NR];
    logic [AW-1:0] am [NR];
    bit            av [NR];
    logic [AW-1:0] sb [NR];
    logic [AW-1:0] sm [NR];
    bit            sv [NR];
    int            mcnt [SETS];
    int            mptr [SETS];

    always #10 clk = ~clk;

    stream_filter #(.ADDR_W(AW), .SETS(SETS), .WAYS(WAYS), .NREG(NR)) uut (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_set(fill_set), .fill_way(fill_way), .qry_addr(qry_addr), .qry_maybe(qry_maybe)
    );

    function automatic bit model_hit(logic [AW-1:0] a);
        bit h = 0;
        for (int i = 0; i < NR; i++) begin
            if (av[i] && (((a ^ ab[i]) & am[i]) == '0)) h = 1;
            if (sv[i] && (((a ^ sb[i]) & sm[i]) == '0)) h = 1;
        end
        return h;
    endfunction

    task automatic model_fill(logic [AW-1:0] a, int s);
        int best = 1000;
        int bi = 0;
        bit full = 1;
        for (int i = 0; i < NR; i++) begin
            int c;
            if (av[i]) c = 2 * $countones((ab[i] ^ a) & am[i]);
            else       c = 1;
            if (c < best) begin
                best = c;
                bi = i;
            end
        end
        if (best == 1) begin
            av[bi] = 1; ab[bi] = a; am[bi] = '1;
        end else if (best >= 2) begin
            am[bi] = am[bi] & ~(ab[bi] ^ a);
        end
        if (mcnt[s] < WAYS) mcnt[s]++;
        mptr[s] = (mptr[s] + 1) % WAYS;
        for (int k = 0; k < SETS; k++) if (mcnt[k] != WAYS) full = 0;
        if (full) begin
            for (int i = 0; i < NR; i++) begin
                sv[i] = av[i]; sb[i] = ab[i]; sm[i] = am[i];
                av[i] = 0; ab[i] = '0; am[i] = '0;
            end
            for (int k = 0; k < SETS; k++) mcnt[k] = 0;
        end
    endtask

    task automatic fill(logic [AW-1:0] a);
        int s = int'(a[1:0]);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = a;
        fill_set   = a[1:0];
        fill_way   = 1'(mptr[s]);
        @(negedge clk);
        fill_valid = 1'b0;
        model_fill(a, s);
    endtask

    task automatic probe(string req, logic [AW-1:0] a, bit exp);
        qry_addr = a;
        #1;
        checks++;
        if (qry_maybe !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%b expected=%b", req, a, qry_maybe, exp);
        end
    endtask

    task automatic sweep(string req);
        @(negedge clk);
        for (int a = 0; a < (1 << AW); a++) probe(req, AW'(a), model_hit(AW'(a)));
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin
            av[i] = 0; sv[i] = 0; ab[i] = '0; am[i] = '0; sb[i] = '0; sm[i] = '0;
        end
        for (int k = 0; k < SETS; k++) begin
            mcnt[k] = 0; mptr[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        sweep("R1");
        // R3: empty register takes the fill with full mask
        fill(12'h100);
        @(negedge clk);
        probe("R3", 12'h100, 1);
        probe("R3", 12'h101, 0);
        // R4: already covered fill changes nothing
        fill(12'h100);
        @(negedge clk);
        probe("R4", 12'h101, 0);
        sweep("R4");
        fill(12'h200);
        fill(12'h400);
        fill(12'h800);
        // R5: merge into the cheapest register
        fill(12'h801);
        @(negedge clk);
        probe("R5", 12'h801, 1);
        probe("R5", 12'h803, 0);
        probe("R5", 12'h100, 1);
        fill(12'h003);
        @(negedge clk);
        probe("R5", 12'h002, 1);
        probe("R5", 12'h004, 0);
        sweep("R5");
        // R6: set 0 saturated, no wrap yet
        fill(12'h802);
        fill(12'h805);
        fill(12'h806);
        @(negedge clk);
        probe("R6", 12'h100, 1);
        sweep("R6");
        fill(12'h007);  // completes the first wrap
        @(negedge clk);
        probe("R7", 12'h100, 1);
        sweep("R7");
        // R9: new epoch in live bank, old epoch in shadow
        fill(12'h0F0);
        @(negedge clk);
        probe("R9", 12'h0F0, 1);
        probe("R9", 12'h100, 1);
        sweep("R9");
        fill(12'h0F4);
        fill(12'h0A1);
        fill(12'h0A5);
        fill(12'h0A2);
        fill(12'h0A6);
        fill(12'h0A3);
        fill(12'h0A7);  // second wrap
        @(negedge clk);
        // R8: old shadow discarded
        probe("R8", 12'h100, 0);
        probe("R8", 12'h0F0, 1);
        probe("R8", 12'h0A4, 1);
        sweep("R8");
        // R2: pseudo-random stream across several wraps
        begin
            logic [AW-1:0] lf = 12'hACE;
            for (int n = 0; n < 90; n++) begin
                lf = {lf[AW-2:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
                fill(lf);
                if (n % 30 == 29) sweep("R2");
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule